// File: doc/BRIEF.md
# Crystal Timebase with Pulse Generators

This block is the shared sense of time for a packet-processing engine. One free-running 56-bit counter advances on every edge of the crystal clock (nominally 19.2 MHz). A programmable divider turns that clock into a slower common tick, 100 kHz when the divide ratio is 192. Three pulse generators count common ticks, and each emits a single-cycle pulse at the end of a period chosen from an eight-entry granularity table. Timers elsewhere in the engine use these pulses as their period reference.

The block also provides three coarse 32-bit timestamps. Each is the 56-bit counter shifted right by its own programmable amount. The first one can instead count a 1 ms reference that is built from the common tick. Software sets all of this through a flat write port with three registers.

The divider is programmed with its ratio minus one, and it has a separate enable bit. The expected sequence is: clear the register, write the new value with enable low, then write the value again with enable high.

Top module: `xtal_timebase`

## Requirements
- R1: After reset the timestamp is 0, all coarse outputs are 0, no pulse is active and the divider is disabled. The reset defaults are: all shifts 0, select clear, all granularity codes 0.
- R2: `stamp_o` increases by exactly one on every clock edge after reset and wraps at 2^56.
- R3: A write to address 1 sets the divider. The value is in bits 8:0 and the enable is bit 31. While enabled with value V, a common tick occurs every V+1 cycles. The first tick is taken at the (V+1)-th edge after the edge that set the enable.
- R4: While the divider is disabled there are no common ticks and no pulses. The divider, generator and 1 ms prescaler counts return to zero, so re-enabling starts a fresh phase.
- R5: A write to address 2 sets the generator codes: generator 0 in bits 2:0, generator 1 in bits 5:3, generator 2 in bits 8:6. The period in common ticks for code 0..7 is 1, 2, 5, 10, 100, 1000, 10000 and 65535 (10 µs to 655.35 ms at 100 kHz).
- R6: A generator with period L pulses `pulse_o[g]` for one cycle after every L-th common tick. With divide ratio r, the first pulse is visible L*r cycles after the enabling edge, and later pulses follow every L*r cycles.
- R7: A write to address 2 restarts every generator's count from zero at the write edge and suppresses any pulse at that edge. The next pulse follows L new common ticks later.
- R8: A write to address 0 sets the coarse shifts: channel 0 in bits 4:0, channel 1 in bits 12:8, channel 2 in bits 20:16. It also sets a select bit in bit 7. Channels 1 and 2, and channel 0 when select is set, show the low 32 bits of the counter shifted right by their shift.
- R9: When select is clear, channel 0 counts completed 1 ms periods, each 100 common ticks. A partial period is discarded when the divider is disabled, and the count itself holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select: 0 timestamp shifts, 1 divider, 2 granularity |
| cfg_wdata_i | input | 32 | Register write data |
| stamp_o | output | 56 | Free-running timestamp |
| coarse_o | output | 3x32 | Coarse timestamps, channel g in element g |
| pulse_o | output | 3 | Single-cycle pulse per generator |

## Verification
The assertions assume that software follows the divider sequence, so the divider value never changes while the enable is set. Under that assumption, two ticks on back-to-back cycles can only mean a value of zero. The stimulus obeys this: every divider change goes through a write with enable low. The bench also rewrites granularity codes only with the divider off, apart from the one deliberate restart test at ratio one. Pulse and 1 ms expectations are computed from the write edges the bench itself records. Each test window ends with a disable write at a known edge, so the expected schedule has a hard upper bound.

// File: rtl/xtb_pkg.sv
package xtb_pkg;

  typedef enum logic [1:0] {
    REG_STAMP = 2'd0,
    REG_DIV   = 2'd1,
    REG_GRAN  = 2'd2
  } xtb_reg_e;

  // Period of a pulse generator in common-clock ticks for a 3-bit code.
  function automatic logic [31:0] gran_ticks(input logic [2:0] code);
    logic [31:0] t;
    case (code)
      3'd0:    t = 32'd1;
      3'd1:    t = 32'd2;
      3'd2:    t = 32'd5;
      3'd3:    t = 32'd10;
      3'd4:    t = 32'd100;
      3'd5:    t = 32'd1000;
      3'd6:    t = 32'd10000;
      default: t = 32'd65535;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/xtb_divider.sv
module xtb_divider #(
  parameter int unsigned DIV_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] val_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap   = (cnt_q >= val_i);
  assign tick_o = en_i & wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i) begin
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/xtb_pulse_gen.sv
module xtb_pulse_gen
  import xtb_pkg::*;
#(
  parameter int unsigned PER_W  = 16,
  parameter int unsigned GRAN_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic [GRAN_W-1:0] code_i,
  output logic              pulse_o
);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] last;
  logic             pulse_q, pulse_d;
  logic             at_end;

  assign last   = PER_W'(gran_ticks(3'(code_i)) - 32'd1);
  assign at_end = (cnt_q >= last);

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (!run_i || restart_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (at_end) begin
        cnt_d   = '0;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/xtb_stamp.sv
module xtb_stamp #(
  parameter int unsigned STAMP_W  = 56,
  parameter int unsigned OUT_W    = 32,
  parameter int unsigned SHIFT_W  = 5,
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned MS_TICKS = 100
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            run_i,
  input  logic                            tick_i,
  input  logic [NUM_CH-1:0][SHIFT_W-1:0]  shift_i,
  input  logic                            sel0_i,
  output logic [STAMP_W-1:0]              stamp_o,
  output logic [NUM_CH-1:0][OUT_W-1:0]    coarse_o
);

  localparam int unsigned PRE_W = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;

  logic [STAMP_W-1:0] stamp_q, stamp_d;
  logic [PRE_W-1:0]   pre_q, pre_d;
  logic [OUT_W-1:0]   ms_q, ms_d;
  logic               ms_en;

  assign stamp_d = stamp_q + 1'b1;
  assign ms_en   = run_i & tick_i & (pre_q == PRE_W'(MS_TICKS - 1));
  assign ms_d    = ms_q + 1'b1;

  always_comb begin
    pre_d = pre_q;
    if (!run_i)       pre_d = '0;
    else if (ms_en)   pre_d = '0;
    else if (tick_i)  pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamp_q <= '0;
      pre_q   <= '0;
      ms_q    <= '0;
    end else begin
      stamp_q <= stamp_d;
      pre_q   <= pre_d;
      if (ms_en) ms_q <= ms_d;
    end
  end

  assign stamp_o = stamp_q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [OUT_W-1:0] shifted;
    assign shifted = OUT_W'(stamp_q >> shift_i[k]);
    if (k == 0) begin : g_sel
      assign coarse_o[k] = sel0_i ? shifted : ms_q;
    end else begin : g_plain
      assign coarse_o[k] = shifted;
    end
  end

endmodule

// File: rtl/xtal_timebase.sv
module xtal_timebase
  import xtb_pkg::*;
#(
  parameter int unsigned STAMP_W  = 56,
  parameter int unsigned OUT_W    = 32,
  parameter int unsigned NUM_GEN  = 3,
  parameter int unsigned DIV_W    = 9,
  parameter int unsigned SHIFT_W  = 5,
  parameter int unsigned GRAN_W   = 3,
  parameter int unsigned PER_W    = 16,
  parameter int unsigned MS_TICKS = 100
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cfg_we_i,
  input  logic [1:0]                      cfg_addr_i,
  input  logic [31:0]                     cfg_wdata_i,
  output logic [STAMP_W-1:0]              stamp_o,
  output logic [NUM_GEN-1:0][OUT_W-1:0]   coarse_o,
  output logic [NUM_GEN-1:0]              pulse_o
);

  localparam int unsigned SHIFT_STRIDE = 8;
  localparam int unsigned SEL_BIT      = 7;
  localparam int unsigned DIV_EN_BIT   = 31;

  logic [NUM_GEN-1:0][SHIFT_W-1:0] stamp_shift_q, stamp_shift_d;
  logic                            stamp_sel_q, stamp_sel_d;
  logic [DIV_W-1:0]                div_val_q, div_val_d;
  logic                            div_en_q, div_en_d;
  logic [NUM_GEN-1:0][GRAN_W-1:0]  gran_q, gran_d;
  logic                            gran_wr;
  logic                            com_tick;
  logic                            unused_wdata;

  assign unused_wdata = ^cfg_wdata_i;
  assign gran_wr      = cfg_we_i & (xtb_reg_e'(cfg_addr_i) == REG_GRAN);

  always_comb begin
    stamp_shift_d = stamp_shift_q;
    stamp_sel_d   = stamp_sel_q;
    div_val_d     = div_val_q;
    div_en_d      = div_en_q;
    gran_d        = gran_q;
    if (cfg_we_i) begin
      case (xtb_reg_e'(cfg_addr_i))
        REG_STAMP: begin
          for (int k = 0; k < NUM_GEN; k++) begin
            stamp_shift_d[k] = cfg_wdata_i[SHIFT_STRIDE*k +: SHIFT_W];
          end
          stamp_sel_d = cfg_wdata_i[SEL_BIT];
        end
        REG_DIV: begin
          div_val_d = cfg_wdata_i[DIV_W-1:0];
          div_en_d  = cfg_wdata_i[DIV_EN_BIT];
        end
        REG_GRAN: begin
          for (int k = 0; k < NUM_GEN; k++) begin
            gran_d[k] = cfg_wdata_i[GRAN_W*k +: GRAN_W];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamp_shift_q <= '0;
      stamp_sel_q   <= 1'b0;
      div_val_q     <= '0;
      div_en_q      <= 1'b0;
      gran_q        <= '0;
    end else if (cfg_we_i) begin
      stamp_shift_q <= stamp_shift_d;
      stamp_sel_q   <= stamp_sel_d;
      div_val_q     <= div_val_d;
      div_en_q      <= div_en_d;
      gran_q        <= gran_d;
    end
  end

  xtb_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (div_en_q),
    .val_i  (div_val_q),
    .tick_o (com_tick)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    xtb_pulse_gen #(.PER_W(PER_W), .GRAN_W(GRAN_W)) u_pg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (div_en_q),
      .tick_i    (com_tick),
      .restart_i (gran_wr),
      .code_i    (gran_q[g]),
      .pulse_o   (pulse_o[g])
    );
  end

  xtb_stamp #(
    .STAMP_W (STAMP_W),
    .OUT_W   (OUT_W),
    .SHIFT_W (SHIFT_W),
    .NUM_CH  (NUM_GEN),
    .MS_TICKS(MS_TICKS)
  ) u_stamp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (div_en_q),
    .tick_i   (com_tick),
    .shift_i  (stamp_shift_q),
    .sel0_i   (stamp_sel_q),
    .stamp_o  (stamp_o),
    .coarse_o (coarse_o)
  );

endmodule

// File: rtl/xtb_checker.sv
module xtb_checker #(
  parameter int unsigned STAMP_W = 56,
  parameter int unsigned OUT_W   = 32,
  parameter int unsigned NUM_GEN = 3,
  parameter int unsigned DIV_W   = 9
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [STAMP_W-1:0] stamp_i,
  input logic [NUM_GEN-1:0] pulse_i,
  input logic [OUT_W-1:0]   coarse0_i,
  input logic               tick_i,
  input logic               div_en_i,
  input logic [DIV_W-1:0]   div_val_i,
  input logic               sel0_i
);

  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (stamp_i == '0 && pulse_i == '0 && coarse0_i == '0));

  a_r2_stamp_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (stamp_i == $past(stamp_i) + 1'b1));

  a_r3_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && tick_i && $past(tick_i)) |-> (div_val_i == '0));

  a_r4_silent_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(div_en_i)) |-> (pulse_i == '0));

  a_r6_pulse_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && pulse_i != '0) |-> $past(tick_i));

  a_r9_ms_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !sel0_i && !$past(sel0_i)) |->
      (coarse0_i == $past(coarse0_i) || coarse0_i == $past(coarse0_i) + 1'b1));

endmodule

bind xtal_timebase xtb_checker #(
  .STAMP_W(STAMP_W), .OUT_W(OUT_W), .NUM_GEN(NUM_GEN), .DIV_W(DIV_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stamp_i   (stamp_o),
  .pulse_i   (pulse_o),
  .coarse0_i (coarse_o[0]),
  .tick_i    (com_tick),
  .div_en_i  (div_en_q),
  .div_val_i (div_val_q),
  .sel0_i    (stamp_sel_q)
);

// File: tb/xtal_timebase_bench.sv
module xtal_timebase_bench;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             we;
  logic [1:0]       addr;
  logic [31:0]      wdata;
  logic [55:0]      stamp;
  logic [2:0][31:0] coarse;
  logic [2:0]       pulse;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int c_rel = 0;
  int ms_exp = 0;
  bit mon_on = 1'b0;
  int exp_q [3][$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xtal_timebase u_xtal_timebase (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .stamp_o(stamp), .coarse_o(coarse), .pulse_o(pulse)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ticks_of(input int code);
    case (code)
      0: return 1;      1: return 2;     2: return 5;     3: return 10;
      4: return 100;    5: return 1000;  6: return 10000;
      default: return 65535;
    endcase
  endfunction

  // Monitor: compares each observed pulse against the scoreboard.
  always @(negedge clk) begin
    if (mon_on) begin
      for (int g = 0; g < 3; g++) begin
        int e;
        while (exp_q[g].size() > 0 && exp_q[g][0] < cyc) begin
          chk(1'b0, $sformatf("R6 missed pulse gen%0d", g), -1, exp_q[g][0]);
          void'(exp_q[g].pop_front());
        end
        if (pulse[g]) begin
          if (exp_q[g].size() == 0) begin
            chk(1'b0, $sformatf("R4 unexpected pulse gen%0d", g), cyc, -1);
          end else begin
            e = exp_q[g].pop_front();
            chk(e == cyc, $sformatf("R6 pulse time gen%0d", g), cyc, e);
          end
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic push_sched(input int g, input int first, input int period, input int last);
    for (int t = first; t <= last; t += period) exp_q[g].push_back(t);
  endtask

  task automatic check_stamp(input string tag);
    chk(stamp == 56'(cyc - c_rel), tag, stamp, cyc - c_rel);
  endtask

  task automatic end_window();
    repeat (5) @(negedge clk);
    for (int g = 0; g < 3; g++)
      chk(exp_q[g].size() == 0, $sformatf("R4 leftover gen%0d", g), exp_q[g].size(), 0);
    chk(coarse[0] == 32'(ms_exp), "R9 ms count", coarse[0], ms_exp);
    check_stamp("R2 stamp");
  endtask

  // Driver: programs a window and pushes the pulse schedule (R3 R5 R6).
  task automatic run_window(input int val, input int c0, input int c1, input int c2, input int n);
    int r, e0, l0, l1, l2;
    r = val + 1;
    wr(2'd1, 32'd0);
    wr(2'd2, 32'(c0 | (c1 << 3) | (c2 << 6)));
    wr(2'd1, 32'(val));
    wr(2'd1, 32'(val) | 32'h8000_0000);
    e0 = cyc;
    l0 = ticks_of(c0); l1 = ticks_of(c1); l2 = ticks_of(c2);
    push_sched(0, e0 + l0 * r, l0 * r, e0 + n);
    push_sched(1, e0 + l1 * r, l1 * r, e0 + n);
    push_sched(2, e0 + l2 * r, l2 * r, e0 + n);
    wait_until(e0 + n - 1);
    wr(2'd1, 32'(val));
    ms_exp += (n / r) / 100;
    end_window();
  endtask

  task automatic restart_window();
    int e0, ew;
    wr(2'd1, 32'd0);
    wr(2'd2, 32'(3 | (3 << 3) | (3 << 6)));
    wr(2'd1, 32'h8000_0000);
    e0 = cyc;
    for (int g = 0; g < 3; g++) push_sched(g, e0 + 10, 10, e0 + 24);
    wait_until(e0 + 24);
    wr(2'd2, 32'(2 | (1 << 3)));   // R7: restart with codes 2,1,0
    ew = cyc;
    chk(ew == e0 + 25, "R7 write edge", ew, e0 + 25);
    push_sched(0, ew + 5, 5, e0 + 60);
    push_sched(1, ew + 2, 2, e0 + 60);
    push_sched(2, ew + 1, 1, e0 + 60);
    wait_until(e0 + 59);
    wr(2'd1, 32'd0);
    end_window();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int m;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    c_rel = cyc;
    // R1 reset state
    chk(stamp == '0, "R1 stamp", stamp, 0);
    chk(pulse == '0, "R1 pulse", pulse, 0);
    for (int k = 0; k < 3; k++) chk(coarse[k] == '0, "R1 coarse", coarse[k], 0);
    mon_on = 1'b1;
    repeat (7) @(negedge clk);
    check_stamp("R2 stamp");

    run_window(0, 0, 1, 2, 250);        // R5 R6 short codes, ratio 1
    run_window(191, 0, 0, 1, 1000);     // R3 ratio 192 (100 kHz)
    run_window(2, 3, 4, 5, 3100);       // R3 R5 ratio 3
    restart_window();                   // R7
    run_window(0, 6, 7, 3, 65600);      // R5 longest codes

    // R4: disabled divider leaves pulses and 1 ms count still
    m = coarse[0];
    repeat (400) @(negedge clk);
    chk(coarse[0] == 32'(m), "R4 hold ms", coarse[0], m);
    chk(pulse == '0, "R4 no pulse", pulse, 0);

    // R8 shifted timestamps
    wr(2'd0, 32'(4 | (1 << 7) | (0 << 8) | (31 << 16)));
    chk(coarse[0] == 32'(56'(cyc - c_rel) >> 4),  "R8 ch0 shift4",  coarse[0], (cyc - c_rel) >> 4);
    chk(coarse[1] == 32'(56'(cyc - c_rel)),       "R8 ch1 shift0",  coarse[1], cyc - c_rel);
    chk(coarse[2] == 32'(56'(cyc - c_rel) >> 31), "R8 ch2 shift31", coarse[2], 0);
    wr(2'd0, 32'(9 | (14 << 8) | (8 << 16)));
    chk(coarse[1] == 32'(56'(cyc - c_rel) >> 14), "R8 ch1 shift14", coarse[1], (cyc - c_rel) >> 14);
    chk(coarse[2] == 32'(56'(cyc - c_rel) >> 8),  "R8 ch2 shift8",  coarse[2], (cyc - c_rel) >> 8);
    chk(coarse[0] == 32'(ms_exp), "R9 select clear", coarse[0], ms_exp);
    check_stamp("R2 stamp end");

    mon_on = 1'b0;
    summary();
    $finish;
  end

endmodule